// File: doc/BRIEF.md
# NAND Port Bus-Width Adapter

This block connects a 32-bit host request stream to a narrow NAND-style I/O port. The port runs either 8 or 16 bits wide. A host request picks one of three windows (command, data, address) and a size of 1, 2 or 4 bytes. The adapter turns each request into a run of device beats. Beats go out little-endian: the lowest bits first. Each beat carries a command-latch or address-latch strobe that matches the window. On a read, the adapter builds the host word from the beats it receives, in the same order. When the run ends, it returns one response.

Both the host request and the host response use valid/ready handshakes. The request side only takes a new request when the block is idle, so `req_ready` stays low from acceptance until the host takes the response. The device side is a valid/ready beat channel: the device can stall any beat by holding `beat_ready` low. Beat data and strobes hold still while stalled. The response holds `rsp_valid` and `rsp_rdata` until `rsp_ready` is high. The configuration pins are sampled when a request is accepted.

Top module: `nand_width_adapter`

## Requirements
- R1: `req_ready` is high only when the block is idle. A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the response handshake completes.
- R2: Device strobes follow the window code (`req_window`):
  - Window 1 (command): every beat has `dev_cle`=1 and `dev_ale`=0.
  - Window 2 (address): every beat has `dev_ale`=1 and `dev_cle`=0.
  - Window 0 (data): every beat has both strobes low.
- R3: On an 8-bit device, sizes 1, 2 and 4 bytes take 1, 2 and 4 beats. The size codes are 0, 1 and 2, and code 3 also means 4 bytes. Beat i carries host byte i on `beat_wdata[7:0]`, with the upper bits zero.
- R4: On a 16-bit device, a 4-byte access is two beats: `req_wdata[15:0]` first, then `req_wdata[31:16]`. A 2-byte access is one beat.
- R5: On a 16-bit device, a 1-byte access is still one beat, and all 16 low bits pass through unchanged. A 1-byte read returns the full 16-bit beat.
- R6: A data-window read places beat i at bits [8i+7:8i] for an 8-bit device, or at [16i+15:16i] for a 16-bit device. The bits above the assembled beats read zero.
- R7: Only `cfg_dev_size[0]` selects the width: 0 means 8-bit and 1 means 16-bit. So codes 2 and 3 act as 8-bit and 16-bit.
- R8: When `cfg_dev_type` is not 2, a request issues no beats and responds with zero read data.
- R9: The following issue no beats and respond with zero:
  - a read from the command or address window;
  - any access to window 3.
- R10: `dev_ce` is high for the whole beat run, across device stalls. Beat data and strobes hold while `beat_ready` is low.
- R11: Timing of a request and its response:
  - The first beat is offered in the cycle right after acceptance. For a request with no beats, the response is offered in that cycle instead.
  - The response is offered in the cycle after the final beat handshake.
  - The response stays offered, unchanged, until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dev_type | input | 2 | Device type code; 2 selects NAND behaviour |
| cfg_dev_size | input | 2 | Device width code; only bit 0 is used |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_window | input | 2 | 0 data, 1 command, 2 address, 3 none |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Assembled read data, zero for writes |
| dev_ce | output | 1 | Chip enable, high through a beat run |
| dev_cle | output | 1 | Command-latch enable |
| dev_ale | output | 1 | Address-latch enable |
| dev_we | output | 1 | Beat direction, 1 = write |
| beat_valid | output | 1 | Device beat offered |
| beat_ready | input | 1 | Device accepts the beat |
| beat_wdata | output | 16 | Beat write data |
| beat_rdata | input | 16 | Beat read data, sampled on the handshake |

## Verification
A request is accepted on a rising edge. In the very next cycle, either the first beat or, for a request with no beats, the response must be offered. The bench checks this at the falling edge that follows acceptance. Each later beat is due once the previous handshake completes. The response is due one cycle after the last beat handshake. A scoreboard on the falling edges pairs every beat and response handshake with the next queued expectation. Any beat that arrives with nothing queued, or a response that arrives while beats are still owed, counts as a failure. Device and response stalls come from fixed patterns, so the handshake cycles shift without changing the expected order.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
  typedef enum logic [1:0] {
    WIN_DATA = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_ADDR = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  localparam logic [1:0] DEV_TYPE_NAND = 2'd2;
endpackage

// File: rtl/nwa_plan.sv
module nwa_plan #(
  parameter int HOST_BYTES = 4,
  parameter int CNT_W      = 3
) (
  input  logic             req_write,
  input  logic [1:0]       req_window,
  input  logic [1:0]       req_size,
  input  logic [1:0]       cfg_dev_type,
  input  logic [1:0]       cfg_dev_size,
  output logic             active,
  output logic             cle,
  output logic             ale,
  output logic             wide,
  output logic [CNT_W-1:0] nbeats
);
  import nwa_pkg::*;

  logic [1:0]       size_sel;
  logic             win_ok;
  logic [CNT_W-1:0] nbytes;

  always_comb begin
    // width select: only the low bit of the size code counts
    size_sel = cfg_dev_size & 2'b01;
    wide     = |size_sel;

    case (req_window)
      WIN_DATA: begin win_ok = 1'b1;      cle = 1'b0; ale = 1'b0; end
      WIN_CMD:  begin win_ok = req_write; cle = 1'b1; ale = 1'b0; end
      WIN_ADDR: begin win_ok = req_write; cle = 1'b0; ale = 1'b1; end
      default:  begin win_ok = 1'b0;      cle = 1'b0; ale = 1'b0; end
    endcase

    active = (cfg_dev_type == DEV_TYPE_NAND) && win_ok;

    if (req_size >= 2'd2) nbytes = CNT_W'(HOST_BYTES);
    else                  nbytes = CNT_W'(1) << req_size;

    if (wide) nbeats = (nbytes > CNT_W'(1)) ? (nbytes >> 1) : CNT_W'(1);
    else      nbeats = nbytes;
  end
endmodule

// File: rtl/nwa_serializer.sv
module nwa_serializer #(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 16,
  parameter int CNT_W  = 3,
  parameter int SH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOST_W-1:0] wdata_in,
  input  logic [CNT_W-1:0]  nbeats_in,
  input  logic              wide_in,
  input  logic              advance,
  output logic [DEV_W-1:0]  beat_data,
  output logic [CNT_W-1:0]  idx,
  output logic              wide,
  output logic              last
);
  localparam int NARROW_W = DEV_W / 2;

  logic [HOST_W-1:0] wdata_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  nbeats_q;
  logic              wide_q;
  logic [SH_W-1:0]   shamt;
  logic [HOST_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q  <= '0;
      idx_q    <= '0;
      nbeats_q <= CNT_W'(1);
      wide_q   <= 1'b0;
    end else if (load) begin
      wdata_q  <= wdata_in;
      idx_q    <= '0;
      nbeats_q <= nbeats_in;
      wide_q   <= wide_in;
    end else if (advance && !last) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  always_comb begin
    shamt   = wide_q ? SH_W'(idx_q) * SH_W'(DEV_W) : SH_W'(idx_q) * SH_W'(NARROW_W);
    shifted = wdata_q >> shamt;
    beat_data = wide_q ? shifted[DEV_W-1:0]
                       : {{(DEV_W-NARROW_W){1'b0}}, shifted[NARROW_W-1:0]};
    last = (idx_q == nbeats_q - CNT_W'(1));
  end

  assign idx  = idx_q;
  assign wide = wide_q;
endmodule

// File: rtl/nwa_assembler.sv
module nwa_assembler #(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              wide,
  input  logic [CNT_W-1:0]  idx,
  input  logic [DEV_W-1:0]  beat_rdata,
  output logic [HOST_W-1:0] acc
);
  localparam int LANES = HOST_W / 8;
  localparam int LPW   = DEV_W / 8;       // byte lanes per wide beat
  localparam int LPN   = (DEV_W / 2) / 8; // byte lanes per narrow beat

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] lane_q;
    logic       hit;
    logic [7:0] byte_in;

    always_comb begin
      hit = capture && (wide ? (idx == CNT_W'(k / LPW)) : (idx == CNT_W'(k / LPN)));
      byte_in = wide ? beat_rdata[(k % LPW)*8 +: 8] : beat_rdata[(k % LPN)*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear) lane_q <= '0;
      else if (hit)        lane_q <= byte_in;
    end

    assign acc[k*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter #(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_dev_type,
  input  logic [1:0]        cfg_dev_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_window,
  input  logic [1:0]        req_size,
  input  logic [HOST_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HOST_W-1:0] rsp_rdata,
  output logic              dev_ce,
  output logic              dev_cle,
  output logic              dev_ale,
  output logic              dev_we,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [DEV_W-1:0]  beat_wdata,
  input  logic [DEV_W-1:0]  beat_rdata
);
  import nwa_pkg::*;

  localparam int HOST_BYTES = HOST_W / 8;
  localparam int CNT_W      = $clog2(HOST_BYTES + 1);
  localparam int SH_W       = $clog2(HOST_W) + 1;

  st_e              state_q;
  logic             cle_q, ale_q, we_q;
  logic             accept, beat_fire;
  logic             p_active, p_cle, p_ale, p_wide;
  logic [CNT_W-1:0] p_nbeats;
  logic [CNT_W-1:0] s_idx;
  logic             s_wide, s_last;

  nwa_plan #(.HOST_BYTES(HOST_BYTES), .CNT_W(CNT_W)) u_plan (
    .req_write(req_write), .req_window(req_window), .req_size(req_size),
    .cfg_dev_type(cfg_dev_type), .cfg_dev_size(cfg_dev_size),
    .active(p_active), .cle(p_cle), .ale(p_ale), .wide(p_wide), .nbeats(p_nbeats)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign beat_valid = (state_q == ST_BEAT);
  assign beat_fire  = beat_valid && beat_ready;
  assign rsp_valid  = (state_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= p_active ? ST_BEAT : ST_RESP;
          cle_q   <= p_cle;
          ale_q   <= p_ale;
          we_q    <= req_write;
        end
        ST_BEAT: if (beat_fire && s_last) state_q <= ST_RESP;
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nwa_serializer #(.HOST_W(HOST_W), .DEV_W(DEV_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .wdata_in(req_wdata),
    .nbeats_in(p_nbeats), .wide_in(p_wide), .advance(beat_fire),
    .beat_data(beat_wdata), .idx(s_idx), .wide(s_wide), .last(s_last)
  );

  nwa_assembler #(.HOST_W(HOST_W), .DEV_W(DEV_W), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture(beat_fire && !we_q),
    .wide(s_wide), .idx(s_idx), .beat_rdata(beat_rdata), .acc(rsp_rdata)
  );

  assign dev_ce  = beat_valid;
  assign dev_cle = beat_valid && cle_q;
  assign dev_ale = beat_valid && ale_q;
  assign dev_we  = beat_valid && we_q;
endmodule

// File: rtl/nwa_checker.sv
module nwa_checker #(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [DEV_W-1:0]  beat_wdata,
  input logic              dev_ce,
  input logic              dev_cle,
  input logic              dev_ale,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [HOST_W-1:0] rsp_rdata
);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !(dev_cle && dev_ale));

  assert_ce_with_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> dev_ce);

  assert_stall_host_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid || rsp_valid) |-> !req_ready);

  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && dev_ce && $stable(beat_wdata)
                                     && $stable(dev_cle) && $stable(dev_ale)));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_exclusive_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_valid && rsp_valid));
endmodule

bind nand_width_adapter nwa_checker #(.HOST_W(HOST_W), .DEV_W(DEV_W)) u_nwa_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_wdata(beat_wdata), .dev_ce(dev_ce),
  .dev_cle(dev_cle), .dev_ale(dev_ale), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/nand_width_adapter_tb.sv
`timescale 1ns/1ps
module nand_width_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_dev_type = 2'd2;
  logic [1:0]  cfg_dev_size = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_window = 2'd0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        dev_ce, dev_cle, dev_ale, dev_we, beat_valid;
  logic        beat_ready = 1'b1;
  logic [15:0] beat_wdata, beat_rdata;

  always #2 clk = ~clk;

  nand_width_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dev_type(cfg_dev_type), .cfg_dev_size(cfg_dev_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_window(req_window), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dev_ce(dev_ce), .dev_cle(dev_cle), .dev_ale(dev_ale), .dev_we(dev_we),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_wdata(beat_wdata),
    .beat_rdata(beat_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // device model: read data depends on a running beat sequence number
  int rd_seq = 0;
  function automatic logic [15:0] rd_val(input int s);
    logic [7:0] b;
    b = s[7:0];
    return {b ^ 8'h5A, b + 8'h31};
  endfunction
  assign beat_rdata = rd_val(rd_seq);

  bit stall_on = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    if (beat_valid && beat_ready && !dev_we) rd_seq <= rd_seq + 1;
    beat_ready <= !stall_on || (cyc % 3 != 1);
    rsp_ready  <= !stall_on || (cyc % 2 == 0);
    cyc <= cyc + 1;
  end

  typedef struct {
    logic        cle;
    logic        ale;
    logic        we;
    logic [15:0] data;
    string       req;
  } beat_t;
  typedef struct {
    logic [31:0] rdata;
    string       req;
  } rsp_t;

  beat_t beat_q[$];
  rsp_t  rsp_q[$];
  int    rsp_seen = 0;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (beat_valid && beat_ready) begin
        if (beat_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected beat", {16'h0, beat_wdata}, 32'h0);
        end else begin
          beat_t e;
          e = beat_q.pop_front();
          chk(dev_cle == e.cle && dev_ale == e.ale, (e.req == "R3") ? "R2" : e.req,
              "strobes cle/ale", {30'h0, dev_cle, dev_ale}, {30'h0, e.cle, e.ale});
          chk(dev_ce == 1'b1, "R10", "chip enable during beat", {31'h0, dev_ce}, 32'h1);
          chk(dev_we == e.we, e.req, "beat direction", {31'h0, dev_we}, {31'h0, e.we});
          if (e.we)
            chk(beat_wdata == e.data, e.req, "beat data", {16'h0, beat_wdata}, {16'h0, e.data});
        end
      end
      if (rsp_valid && rsp_ready) begin
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected response", rsp_rdata, 32'h0);
        end else begin
          rsp_t r;
          r = rsp_q.pop_front();
          chk(rsp_rdata == r.rdata, r.req, "response data", rsp_rdata, r.rdata);
          chk(beat_q.size() == 0, "R11", "beats outstanding at response",
              beat_q.size(), 32'h0);
        end
        rsp_seen <= rsp_seen + 1;
      end
    end
  end

  task automatic op(input logic w, input logic [1:0] win, input logic [1:0] sz,
                    input logic [31:0] d, input string req);
    bit          active, wide;
    int          nbytes, nb, target;
    logic [31:0] exp_rd;
    active = (cfg_dev_type == 2'd2) && (win == 2'd0 || (w && (win == 2'd1 || win == 2'd2)));
    wide   = cfg_dev_size[0];
    nbytes = (sz >= 2'd2) ? 4 : (1 << sz);
    nb     = wide ? ((nbytes > 1) ? nbytes / 2 : 1) : nbytes;
    exp_rd = '0;
    if (active) begin
      for (int i = 0; i < nb; i++) begin
        beat_t e;
        e.cle = (win == 2'd1);
        e.ale = (win == 2'd2);
        e.we  = w;
        e.data = wide ? 16'(d >> (16 * i)) : {8'h0, 8'(d >> (8 * i))};
        e.req = req;
        beat_q.push_back(e);
        if (!w) begin
          if (wide) exp_rd = exp_rd | (32'(rd_val(rd_seq + i)) << (16 * i));
          else      exp_rd = exp_rd | (32'(rd_val(rd_seq + i) & 16'h00FF) << (8 * i));
        end
      end
    end
    begin
      rsp_t r;
      r.rdata = exp_rd;
      r.req = req;
      rsp_q.push_back(r);
    end
    target = rsp_seen + 1;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_window = win; req_size = sz; req_wdata = d;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready when idle", {31'h0, req_ready}, 32'h1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready low after accept", {31'h0, req_ready}, 32'h0);
    if (active) chk(beat_valid == 1'b1, "R11", "first beat next cycle", {31'h0, beat_valid}, 32'h1);
    else        chk(rsp_valid == 1'b1, "R11", "response next cycle", {31'h0, rsp_valid}, 32'h1);
    while (rsp_seen < target) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && beat_valid == 1'b0 && rsp_valid == 1'b0 && dev_ce == 1'b0,
        "R1", "reset state", {28'h0, req_ready, beat_valid, rsp_valid, dev_ce}, 32'h8);

    // 8-bit device
    cfg_dev_type = 2'd2; cfg_dev_size = 2'd0;
    op(1'b1, 2'd1, 2'd0, 32'h0000_00A5, "R2");  // command byte
    op(1'b1, 2'd2, 2'd2, 32'h4433_2211, "R3");  // address, four beats
    op(1'b1, 2'd0, 2'd1, 32'h0000_BEEF, "R3");  // data, two beats
    op(1'b1, 2'd0, 2'd3, 32'hDEAD_C0DE, "R3");  // size code 3 = four bytes
    op(1'b0, 2'd0, 2'd2, 32'h0, "R6");          // read four bytes
    op(1'b0, 2'd0, 2'd0, 32'h0, "R6");          // read one byte, upper zero

    // 16-bit device
    cfg_dev_size = 2'd1;
    op(1'b1, 2'd0, 2'd2, 32'hCAFE_1234, "R4");
    op(1'b1, 2'd2, 2'd1, 32'h0000_5678, "R4");
    op(1'b1, 2'd0, 2'd0, 32'h0000_9ABC, "R5");  // one byte, 16 bits pass through
    op(1'b0, 2'd0, 2'd0, 32'h0, "R5");
    op(1'b0, 2'd0, 2'd2, 32'h0, "R6");

    // reserved width codes
    cfg_dev_size = 2'd3;
    op(1'b1, 2'd0, 2'd2, 32'h8765_4321, "R7");
    cfg_dev_size = 2'd2;
    op(1'b1, 2'd0, 2'd2, 32'h0F1E_2D3C, "R7");

    // not a NAND chip select
    cfg_dev_type = 2'd0;
    op(1'b1, 2'd1, 2'd0, 32'h0000_0070, "R8");
    op(1'b0, 2'd0, 2'd2, 32'h0, "R8");
    cfg_dev_type = 2'd3;
    op(1'b1, 2'd0, 2'd2, 32'h1111_2222, "R8");

    // reads from latch windows, window 3
    cfg_dev_type = 2'd2; cfg_dev_size = 2'd0;
    op(1'b0, 2'd1, 2'd2, 32'h0, "R9");
    op(1'b0, 2'd2, 2'd0, 32'h0, "R9");
    op(1'b1, 2'd3, 2'd2, 32'h5555_AAAA, "R9");

    // stalls on device and response sides
    stall_on = 1'b1;
    op(1'b1, 2'd2, 2'd2, 32'hA1B2_C3D4, "R10");
    op(1'b0, 2'd0, 2'd2, 32'h0, "R11");
    cfg_dev_size = 2'd1;
    op(1'b1, 2'd1, 2'd2, 32'h0102_0304, "R10");
    op(1'b0, 2'd0, 2'd2, 32'h0, "R11");
    stall_on = 1'b0;

    repeat (4) @(negedge clk);
    chk(beat_q.size() == 0 && rsp_q.size() == 0, "R11", "scoreboard drained",
        beat_q.size() + rsp_q.size(), 32'h0);
    finish_run();
  end
endmodule